// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Match Unit

This block watches the buses of an 8-bit controller core on behalf of an on-chip debugger. It sees every program fetch address and every access the core makes to internal data memory, external data memory and special-function registers. A bank of identical comparator slots holds the match conditions. Each slot is configured through a simple write port. It can act as a program breakpoint on a fetch address. It can also act as a data breakpoint or watchpoint in one of the three data spaces. A watchpoint can be qualified by access direction and, optionally, by an exact data pattern.

When a slot matches, the unit raises a sticky per-slot hit flag and a halt request. Both stay asserted until the debugger clears them. A program breakpoint also drives the halt request combinationally in the fetch cycle, so the core can stop before the matching instruction executes. The unit also produces a run indicator and a debugger-access indicator. When no slot is enabled, the unit reports idle and forces its comparator inputs to zero.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every slot is disabled, `hit_o` is all zero, `halt_o` is 0 and `idle_o` is 1. A cycle with `cfg_we_i` high loads all fields of slot `cfg_slot_i`, which takes effect from the next cycle.
- R2: A slot with space code 0 (program) matches when `fetch_valid_i` is high and `fetch_addr_i` equals its address. `halt_o` rises in that same cycle, before the instruction executes.
- R3: A slot with space code 1 (internal data), 2 (external data) or 3 (special-function registers) matches a valid access only when `acc_space_i` equals its space code and `acc_addr_i` equals its address. A write (`acc_we_i`=1) also needs the slot's write enable; a read (`acc_we_i`=0) also needs its read enable.
- R4: With pattern enable set, a data-space slot matches only if `acc_data_i` equals its data register. With pattern enable clear, the access data has no effect on the match.
- R5: An access with `acc_dbg_i`=1 never causes a match.
- R6: A match sets bit i of `hit_o` for slot i on the next clock edge. The bit holds until `hit_clr_i` is high. If a match and `hit_clr_i` happen in the same cycle, the bit ends up set.
- R7: From the cycle after any match, `halt_o` stays high until a clear. It stays high even when no further match occurs.
- R8: `run_o` is high exactly when `exec_i` is high and `halt_o` is low.
- R9: `dbg_acs_o` is high exactly when `acc_valid_i` and `acc_dbg_i` are both high.
- R10: When no slot is enabled, `idle_o` is 1 and no fetch or access produces a hit.
- R11: A slot whose enable bit is clear never matches, even when every other field matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write the slot configuration |
| cfg_slot_i | input | SLOT_W | Slot index to write |
| cfg_en_i | input | 1 | Slot enable |
| cfg_space_i | input | 2 | Space: 0 program, 1 internal data, 2 external data, 3 SFR |
| cfg_rd_i | input | 1 | Match on reads |
| cfg_wr_i | input | 1 | Match on writes |
| cfg_pat_i | input | 1 | Require a data-pattern match |
| cfg_addr_i | input | AW | Match address |
| cfg_data_i | input | DW | Match data pattern |
| hit_clr_i | input | 1 | Clear hit flags and halt request |
| fetch_valid_i | input | 1 | Program fetch in this cycle |
| fetch_addr_i | input | AW | Program fetch address |
| acc_valid_i | input | 1 | Data access in this cycle |
| acc_space_i | input | 2 | Space of the data access |
| acc_we_i | input | 1 | 1 write, 0 read |
| acc_addr_i | input | AW | Data access address |
| acc_data_i | input | DW | Data read or written |
| acc_dbg_i | input | 1 | Access issued by the debugger |
| exec_i | input | 1 | Core is executing an instruction |
| hit_o | output | NSLOT | Sticky per-slot hit flags |
| halt_o | output | 1 | Halt request |
| run_o | output | 1 | Core running indicator |
| dbg_acs_o | output | 1 | Debugger access indicator |
| idle_o | output | 1 | No slot enabled, comparators idle |

## Verification
Assertions check on every cycle that hit flags never drop without a clear, that a match always shows up as a set flag, and that the halt request tracks the flags. They also check that debugger accesses and disabled slots never match, that the idle state yields no match, and that a program match is followed by a halt. The bench's scenarios are the only check on the actual match decisions. These cover address, space and direction mismatches, pattern hits and misses, and the combinational halt in the fetch cycle. They also cover the set-over-clear priority and which slot bit a multi-slot hit lands on.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;
  typedef enum logic [1:0] {
    SPC_CODE  = 2'd0,
    SPC_IDATA = 2'd1,
    SPC_XDATA = 2'd2,
    SPC_SFR   = 2'd3
  } space_e;
endpackage

// File: rtl/dbg_slot.sv
module dbg_slot
  import dbg_match_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          en_i,
  input  logic [1:0]    space_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic          pat_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          acc_valid_i,
  input  logic [1:0]    acc_space_i,
  input  logic          acc_we_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] acc_data_i,
  input  logic          acc_dbg_i,
  output logic          en_o,
  output logic          code_hit_o,
  output logic          data_hit_o
);
  logic          en_q, rd_q, wr_q, pat_q;
  logic [1:0]    space_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      pat_q   <= 1'b0;
      space_q <= SPC_CODE;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (wr_i) begin
      en_q    <= en_i;
      rd_q    <= rd_en_i;
      wr_q    <= wr_en_i;
      pat_q   <= pat_en_i;
      space_q <= space_i;
      addr_q  <= addr_i;
      data_q  <= data_i;
    end
  end

  logic is_code, dir_ok, data_ok;
  assign is_code = (space_q == SPC_CODE);
  assign dir_ok  = acc_we_i ? wr_q : rd_q;
  assign data_ok = !pat_q || (acc_data_i == data_q);

  assign en_o       = en_q;
  assign code_hit_o = en_q && is_code && fetch_valid_i && (fetch_addr_i == addr_q);
  assign data_hit_o = en_q && !is_code && acc_valid_i && !acc_dbg_i &&
                      (acc_space_i == space_q) && (acc_addr_i == addr_q) &&
                      dir_ok && data_ok;

  // R5
  dbg_no_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_dbg_i |-> !data_hit_o);
  // R11
  slot_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !(code_hit_o || data_hit_o));
endmodule

// File: rtl/dbg_hit_ctrl.sv
module dbg_hit_ctrl #(
  parameter int NSLOT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSLOT-1:0] match_i,
  input  logic             clr_i,
  output logic [NSLOT-1:0] hit_o,
  output logic             halt_o
);
  logic [NSLOT-1:0] hit_q;
  logic             halt_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      hit_q  <= (clr_i ? '0 : hit_q) | match_i;
      halt_q <= (clr_i ? 1'b0 : halt_q) | (|match_i);
    end
  end

  assign hit_o  = hit_q;
  assign halt_o = halt_q;

  // R6
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (($past(hit_q) & ~hit_q) == '0));
  // R6
  match_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i != '0) |=> ((hit_q & $past(match_i)) == $past(match_i)));
  // R7
  halt_tracks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q == (hit_q != '0));
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_match_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int AW     = 24,
  parameter int DW     = 8,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic              cfg_en_i,
  input  logic [1:0]        cfg_space_i,
  input  logic              cfg_rd_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_pat_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [DW-1:0]     cfg_data_i,
  input  logic              hit_clr_i,
  input  logic              fetch_valid_i,
  input  logic [AW-1:0]     fetch_addr_i,
  input  logic              acc_valid_i,
  input  logic [1:0]        acc_space_i,
  input  logic              acc_we_i,
  input  logic [AW-1:0]     acc_addr_i,
  input  logic [DW-1:0]     acc_data_i,
  input  logic              acc_dbg_i,
  input  logic              exec_i,
  output logic [NSLOT-1:0]  hit_o,
  output logic              halt_o,
  output logic              run_o,
  output logic              dbg_acs_o,
  output logic              idle_o
);
  logic [NSLOT-1:0] slot_en, code_hit, data_hit, match;
  logic             any_en, halt_q;

  assign any_en = |slot_en;

  // comparator inputs held at zero while idle
  logic          g_fvalid, g_avalid, g_we, g_dbg;
  logic [AW-1:0] g_faddr, g_aaddr;
  logic [DW-1:0] g_adata;
  logic [1:0]    g_aspace;
  assign g_fvalid = fetch_valid_i & any_en;
  assign g_faddr  = fetch_addr_i & {AW{any_en}};
  assign g_avalid = acc_valid_i & any_en;
  assign g_aspace = acc_space_i & {2{any_en}};
  assign g_we     = acc_we_i & any_en;
  assign g_aaddr  = acc_addr_i & {AW{any_en}};
  assign g_adata  = acc_data_i & {DW{any_en}};
  assign g_dbg    = acc_dbg_i & any_en;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    dbg_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .wr_i          (cfg_we_i && (cfg_slot_i == SLOT_W'(i))),
      .en_i          (cfg_en_i),
      .space_i       (cfg_space_i),
      .rd_en_i       (cfg_rd_i),
      .wr_en_i       (cfg_wr_i),
      .pat_en_i      (cfg_pat_i),
      .addr_i        (cfg_addr_i),
      .data_i        (cfg_data_i),
      .fetch_valid_i (g_fvalid),
      .fetch_addr_i  (g_faddr),
      .acc_valid_i   (g_avalid),
      .acc_space_i   (g_aspace),
      .acc_we_i      (g_we),
      .acc_addr_i    (g_aaddr),
      .acc_data_i    (g_adata),
      .acc_dbg_i     (g_dbg),
      .en_o          (slot_en[i]),
      .code_hit_o    (code_hit[i]),
      .data_hit_o    (data_hit[i])
    );
  end

  assign match = code_hit | data_hit;

  dbg_hit_ctrl #(.NSLOT(NSLOT)) u_hit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (match),
    .clr_i   (hit_clr_i),
    .hit_o   (hit_o),
    .halt_o  (halt_q)
  );

  // program breakpoint stops the core in the fetch cycle
  assign halt_o    = halt_q | (|code_hit);
  assign run_o     = exec_i & ~halt_o;
  assign dbg_acs_o = acc_valid_i & acc_dbg_i;
  assign idle_o    = ~any_en;

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (match == '0));
  // R2
  code_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_hit != '0) |=> halt_o);
  // R8
  run_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !run_o);
endmodule

// File: tb/dbg_match_unit_bench.sv
`timescale 1ns/1ps
module dbg_match_unit_bench;
  localparam int NSLOT = 4;
  localparam int AW = 24;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] cfg_slot;
  logic cfg_we, cfg_en, cfg_rd, cfg_wr, cfg_pat, hit_clr;
  logic [1:0] cfg_space, acc_space;
  logic [AW-1:0] cfg_addr, fetch_addr, acc_addr;
  logic [DW-1:0] cfg_data, acc_data;
  logic fetch_valid, acc_valid, acc_we, acc_dbg, exec;
  logic [NSLOT-1:0] hit;
  logic halt, run, dbg_acs, idle;

  dbg_match_unit #(.NSLOT(NSLOT), .AW(AW), .DW(DW)) u_dbg_match_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot), .cfg_en_i(cfg_en),
    .cfg_space_i(cfg_space), .cfg_rd_i(cfg_rd), .cfg_wr_i(cfg_wr),
    .cfg_pat_i(cfg_pat), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .hit_clr_i(hit_clr),
    .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr),
    .acc_valid_i(acc_valid), .acc_space_i(acc_space), .acc_we_i(acc_we),
    .acc_addr_i(acc_addr), .acc_data_i(acc_data), .acc_dbg_i(acc_dbg),
    .exec_i(exec),
    .hit_o(hit), .halt_o(halt), .run_o(run), .dbg_acs_o(dbg_acs), .idle_o(idle)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_slot_w(input logic [1:0] s, input logic en, input logic [1:0] sp,
                            input logic rd, input logic wr, input logic pat,
                            input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = s; cfg_en = en; cfg_space = sp;
    cfg_rd = rd; cfg_wr = wr; cfg_pat = pat; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_hits();
    @(negedge clk); hit_clr = 1'b1;
    @(negedge clk); hit_clr = 1'b0;
  endtask

  task automatic do_access(input logic [1:0] sp, input logic we, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic dbg);
    @(negedge clk);
    acc_valid = 1'b1; acc_space = sp; acc_we = we; acc_addr = a; acc_data = d; acc_dbg = dbg;
    @(negedge clk);
    acc_valid = 1'b0; acc_dbg = 1'b0;
  endtask

  task automatic do_fetch(input logic [AW-1:0] a);
    @(negedge clk); fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk); fetch_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]    sp;
    logic          rd, wr, pat;
    logic [AW-1:0] addr;
    logic [DW-1:0] pdat;
    logic          fetch;
    logic [1:0]    asp;
    logic          we;
    logic [AW-1:0] aaddr;
    logic [DW-1:0] adat;
    logic          dbg;
    logic          exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 24'h001234, 8'h00, 1'b1, 2'd0, 1'b0, 24'h001234, 8'h00, 1'b0, 1'b1}, // R2 hit
    '{2'd0, 1'b0, 1'b0, 1'b0, 24'h001234, 8'h00, 1'b1, 2'd0, 1'b0, 24'h001235, 8'h00, 1'b0, 1'b0}, // R2 miss
    '{2'd1, 1'b1, 1'b0, 1'b0, 24'h000040, 8'h00, 1'b0, 2'd1, 1'b0, 24'h000040, 8'h11, 1'b0, 1'b1}, // R3 read
    '{2'd1, 1'b1, 1'b0, 1'b0, 24'h000040, 8'h00, 1'b0, 2'd1, 1'b1, 24'h000040, 8'h11, 1'b0, 1'b0}, // R3 dir
    '{2'd2, 1'b0, 1'b1, 1'b1, 24'h000100, 8'hA5, 1'b0, 2'd2, 1'b1, 24'h000100, 8'hA5, 1'b0, 1'b1}, // R4 pat hit
    '{2'd2, 1'b0, 1'b1, 1'b1, 24'h000100, 8'hA5, 1'b0, 2'd2, 1'b1, 24'h000100, 8'h5A, 1'b0, 1'b0}, // R4 pat miss
    '{2'd3, 1'b1, 1'b1, 1'b0, 24'h000010, 8'h00, 1'b0, 2'd1, 1'b1, 24'h000010, 8'h00, 1'b0, 1'b0}, // R3 space
    '{2'd3, 1'b1, 1'b1, 1'b0, 24'h000010, 8'h00, 1'b0, 2'd3, 1'b0, 24'h000010, 8'h33, 1'b0, 1'b1}, // R3 sfr
    '{2'd2, 1'b1, 1'b0, 1'b1, 24'h00ABCD, 8'h7E, 1'b0, 2'd2, 1'b0, 24'h00ABCD, 8'h7E, 1'b1, 1'b0}, // R5 dbg
    '{2'd1, 1'b0, 1'b1, 1'b0, 24'h000077, 8'hFF, 1'b0, 2'd1, 1'b1, 24'h000077, 8'h3C, 1'b0, 1'b1}  // R4 no pat
  };

  initial begin : watchdog
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cfg_we = 0; cfg_slot = 0; cfg_en = 0; cfg_space = 0; cfg_rd = 0; cfg_wr = 0;
    cfg_pat = 0; cfg_addr = 0; cfg_data = 0; hit_clr = 0; fetch_valid = 0;
    fetch_addr = 0; acc_valid = 0; acc_space = 0; acc_we = 0; acc_addr = 0;
    acc_data = 0; acc_dbg = 0; exec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 hit", 32'(hit), 32'h0);
    check("R1 halt", 32'(halt), 32'h0);
    check("R1 idle", 32'(idle), 32'h1);
    exec = 1'b1;
    #1 check("R8 run", 32'(run), 32'h1);

    for (int v = 0; v < NV; v++) begin
      clear_hits();
      cfg_slot_w(2'd0, 1'b1, VECS[v].sp, VECS[v].rd, VECS[v].wr, VECS[v].pat,
                 VECS[v].addr, VECS[v].pdat);
      if (VECS[v].fetch) do_fetch(VECS[v].aaddr);
      else do_access(VECS[v].asp, VECS[v].we, VECS[v].aaddr, VECS[v].adat, VECS[v].dbg);
      check($sformatf("R3/R4/R5/R6 vec%0d hit", v), 32'(hit), 32'(VECS[v].exp));
      check($sformatf("R7 vec%0d halt", v), 32'(halt), 32'(VECS[v].exp));
    end

    // R2 halt in the fetch cycle, before the flag registers
    clear_hits();
    cfg_slot_w(2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 24'h000800, 8'h00);
    @(negedge clk); fetch_valid = 1'b1; fetch_addr = 24'h000800;
    #1;
    check("R2 same-cycle halt", 32'(halt), 32'h1);
    check("R2 flag not yet set", 32'(hit), 32'h0);
    check("R8 run low while halted", 32'(run), 32'h0);
    @(negedge clk); fetch_valid = 1'b0;
    check("R6 code hit flag", 32'(hit), 32'h1);
    repeat (3) @(negedge clk);
    check("R7 halt held", 32'(halt), 32'h1);
    check("R6 flag held", 32'(hit), 32'h1);
    clear_hits();
    check("R7 halt cleared", 32'(halt), 32'h0);
    check("R6 flag cleared", 32'(hit), 32'h0);

    // R6 set wins over clear in the same cycle
    cfg_slot_w(2'd1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 24'h000022, 8'h00);
    @(negedge clk);
    hit_clr = 1'b1; acc_valid = 1'b1; acc_space = 2'd1; acc_we = 1'b0; acc_addr = 24'h000022;
    @(negedge clk);
    hit_clr = 1'b0; acc_valid = 1'b0;
    check("R6 set beats clear", 32'(hit), 32'h2);

    // multi-slot: only slot 3 bit
    clear_hits();
    cfg_slot_w(2'd3, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 24'h000005, 8'h00);
    do_access(2'd3, 1'b1, 24'h000005, 8'h99, 1'b0);
    check("R6 slot3 bit", 32'(hit), 32'h8);

    // R9 debugger access indicator
    @(negedge clk); acc_valid = 1'b1; acc_dbg = 1'b1; acc_space = 2'd2; acc_addr = 24'h0;
    #1 check("R9 dbg access", 32'(dbg_acs), 32'h1);
    acc_dbg = 1'b0;
    #1 check("R9 cpu access", 32'(dbg_acs), 32'h0);
    @(negedge clk); acc_valid = 1'b0;

    // R11 disabled slot with matching fields, R10 idle with all off
    clear_hits();
    cfg_slot_w(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 24'h000800, 8'h00);
    cfg_slot_w(2'd1, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 24'h000022, 8'h00);
    check("R10 not idle while slot3 on", 32'(idle), 32'h0);
    do_fetch(24'h000800);
    do_access(2'd1, 1'b0, 24'h000022, 8'h00, 1'b0);
    check("R11 disabled slots no hit", 32'(hit), 32'h0);
    cfg_slot_w(2'd3, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 24'h000005, 8'h00);
    check("R10 idle", 32'(idle), 32'h1);
    do_access(2'd3, 1'b1, 24'h000005, 8'h00, 1'b0);
    check("R10 no hit when idle", 32'(hit), 32'h0);
    check("R10 no halt when idle", 32'(halt), 32'h0);
    check("R8 run resumes", 32'(run), 32'h1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule